// File: doc/BRIEF.md
# Interval Slowdown Estimator

This unit watches per-cycle event strobes from a shared cache, its companion tag-store sampler and the memory scheduler. For every application sharing those resources it forms a fixed-point estimate of how much slower that application runs than it would on an idle machine. The estimate is the application's estimated standalone cache access rate divided by its measured shared cache access rate. The standalone rate is rebuilt from what the application achieved while it held top priority at the memory controller. Two corrections are removed from those priority cycles first: cycles lost to cache contention misses, and cycles spent queued behind another application's request.

Time is cut into back-to-back intervals of `INTERVAL_LEN` cycles, and the first interval starts on the first clock edge after reset. At the last cycle of an interval every counter is captured and cleared. A sequencer then walks the applications in ascending order and uses one shared iterative divider twice per application: once for the mean miss service time and once for the slowdown ratio.

Results leave on a valid/ready stream, one transfer per application. While `sd_valid` is high and `sd_ready` is low, the result is held unchanged and the sequencer waits. If an interval ends while the previous interval's results are still being produced or held, that interval's capture is dropped: its counters clear and it yields no results.

Top module: `slowdown_estimator`

## Requirements
- R1: While reset is asserted and until the first results are ready, `sd_valid` is low and `sd_value` is 0.
- R2: Each captured interval produces exactly N_APPS transfers with `sd_app` = 0, 1, …, N_APPS-1 in that order. Each interval is exactly INTERVAL_LEN cycles long, and the shared access count is the number of cycles the application's `acc_hit` bit is high within it.
- R3: A cycle counts as a priority cycle for application a only when `hp_active` is 1 and `hp_owner` = a. Priority accesses, priority cycles and contention misses (`cont_miss`) are counted only in such cycles.
- R4: A miss is in service from the cycle after its `miss_start` strobe through its `miss_done` strobe. Its service cycles add to the application's service sum only while the application holds priority. The finish adds to its miss count only when priority is held in the finish cycle. The mean service time is floor(sum/count), or 0 when the count is 0.
- R5: Contention cycles = priority contention misses × mean service time.
- R6: A priority cycle of application a is a queueing cycle when `req_pending[a]` is 1 and the most recent `grant_valid` cycle (strictly earlier, at any time since reset) carried a `grant_id` other than a. Before any grant there are no queueing cycles.
- R7: Corrected cycles = priority cycles − contention cycles − queueing cycles. If this is zero or negative, 1 is used and `sd_invalid` is 1 for that result, otherwise 0.
- R8: `sd_value` is unsigned Q8.8 (8 fraction bits): floor(priority_accesses × INTERVAL_LEN × 256 / (corrected_cycles × max(shared_accesses,1))), saturated to 16'hFFFF.
- R9: While `sd_valid` is 1 and `sd_ready` is 0, `sd_valid`, `sd_app`, `sd_value` and `sd_invalid` stay unchanged.
- R10: An interval that ends while results of an earlier interval are still pending produces no results.
- R11: Every counter restarts from zero at each interval, so results depend only on events inside that interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_hit | input | N_APPS | Shared cache access this cycle, one bit per application |
| hp_active | input | 1 | A priority epoch is in force this cycle |
| hp_owner | input | ID_W | Application holding priority |
| cont_miss | input | N_APPS | Contention miss reported by the tag-store sampler |
| miss_start | input | N_APPS | Miss service begins |
| miss_done | input | N_APPS | Miss service ends |
| grant_valid | input | 1 | Memory scheduler issued a request |
| grant_id | input | ID_W | Application whose request was issued |
| req_pending | input | N_APPS | Application has a memory request outstanding |
| sd_valid | output | 1 | Result available |
| sd_ready | input | 1 | Consumer accepts the result |
| sd_app | output | ID_W | Application the result belongs to |
| sd_value | output | 16 | Slowdown, unsigned Q8.8 |
| sd_invalid | output | 1 | Corrected cycle count was clamped to 1 |

## Verification
Several corner cases get dedicated stimulus. An idle interval checks that the zero-cycle denominator raises the invalid flag with a zero result; a design that divided by the raw count would give all-ones or garbage. A two-cycle priority burst lands exactly on 65536, so a missing saturation would wrap the value to zero. One interval piles enough contention misses on an application to drive its corrected cycle count negative, which exposes a signed-compare error. Another mixes grants and pending requests, so a queueing test that uses the current grant instead of the previous one gives different results. Long holds of `sd_ready` low check that the result stays frozen and that the interval ending during the stall yields nothing. A design that overwrote its capture would emit that interval's values in place of the later ones.

// File: rtl/slowdown_estimator_pkg.sv
package slowdown_estimator_pkg;
  localparam int OUT_W  = 16;
  localparam int FRAC_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_AVG_GO,
    ST_AVG_WAIT,
    ST_PREP,
    ST_MAIN_GO,
    ST_MAIN_WAIT,
    ST_OUT
  } eng_state_e;
endpackage

// File: rtl/sde_interval_timer.sv
module sde_interval_timer #(
  parameter int INTERVAL_LEN = 512,
  localparam int TW = (INTERVAL_LEN > 1) ? $clog2(INTERVAL_LEN) : 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  logic [TW-1:0] cyc_q;

  assign tick = (cyc_q == TW'(INTERVAL_LEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cyc_q <= '0;
    else if (tick) cyc_q <= '0;
    else           cyc_q <= cyc_q + 1'b1;
  end
endmodule

// File: rtl/sde_event_counters.sv
module sde_event_counters #(
  parameter int N_APPS = 4,
  parameter int ID_W   = 2,
  parameter int CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [N_APPS-1:0] acc_hit,
  input  logic              hp_active,
  input  logic [ID_W-1:0]   hp_owner,
  input  logic [N_APPS-1:0] cont_miss,
  input  logic [N_APPS-1:0] miss_start,
  input  logic [N_APPS-1:0] miss_done,
  input  logic              grant_valid,
  input  logic [ID_W-1:0]   grant_id,
  input  logic [N_APPS-1:0] req_pending,
  output logic [CNT_W-1:0]  sh_nxt  [N_APPS],
  output logic [CNT_W-1:0]  hpa_nxt [N_APPS],
  output logic [CNT_W-1:0]  hpc_nxt [N_APPS],
  output logic [CNT_W-1:0]  cm_nxt  [N_APPS],
  output logic [CNT_W-1:0]  svc_nxt [N_APPS],
  output logic [CNT_W-1:0]  scn_nxt [N_APPS],
  output logic [CNT_W-1:0]  q_nxt   [N_APPS]
);
  // Most recent scheduler grant, kept across intervals.
  logic            last_v_q;
  logic [ID_W-1:0] last_id_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_v_q  <= 1'b0;
      last_id_q <= '0;
    end else if (grant_valid) begin
      last_v_q  <= 1'b1;
      last_id_q <= grant_id;
    end
  end

  for (genvar a = 0; a < N_APPS; a++) begin : g_app
    logic             own;
    logic             busy_q;
    logic             queued;
    logic [CNT_W-1:0] sh_q, hpa_q, hpc_q, cm_q, svc_q, scn_q, q_q;

    assign own    = hp_active && (hp_owner == ID_W'(a));
    assign queued = own && req_pending[a] && last_v_q && (last_id_q != ID_W'(a));

    assign sh_nxt[a]  = sh_q  + CNT_W'(acc_hit[a]);
    assign hpa_nxt[a] = hpa_q + CNT_W'(own && acc_hit[a]);
    assign hpc_nxt[a] = hpc_q + CNT_W'(own);
    assign cm_nxt[a]  = cm_q  + CNT_W'(own && cont_miss[a]);
    assign svc_nxt[a] = svc_q + CNT_W'(own && busy_q);
    assign scn_nxt[a] = scn_q + CNT_W'(own && busy_q && miss_done[a]);
    assign q_nxt[a]   = q_q   + CNT_W'(queued);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) busy_q <= 1'b0;
      else        busy_q <= (busy_q | miss_start[a]) & ~miss_done[a];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n || tick) begin
        sh_q  <= '0;
        hpa_q <= '0;
        hpc_q <= '0;
        cm_q  <= '0;
        svc_q <= '0;
        scn_q <= '0;
        q_q   <= '0;
      end else begin
        sh_q  <= sh_nxt[a];
        hpa_q <= hpa_nxt[a];
        hpc_q <= hpc_nxt[a];
        cm_q  <= cm_nxt[a];
        svc_q <= svc_nxt[a];
        scn_q <= scn_nxt[a];
        q_q   <= q_nxt[a];
      end
    end
  end
endmodule

// File: rtl/sde_seq_divider.sv
module sde_seq_divider #(
  parameter int W = 28,
  localparam int CW = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         done,
  output logic [W-1:0] quo
);
  logic [W-1:0]  rem_q, den_q, quo_q;
  logic [CW-1:0] cnt_q;
  logic          run_q, done_q;
  logic [W:0]    trial;
  logic          ge;

  assign trial = {rem_q, quo_q[W-1]};
  assign ge    = trial >= {1'b0, den_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      den_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        rem_q <= '0;
        den_q <= den;
        quo_q <= num;
        cnt_q <= CW'(W - 1);
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= ge ? W'(trial - {1'b0, den_q}) : trial[W-1:0];
        quo_q <= {quo_q[W-2:0], ge};
        if (cnt_q == '0) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign done = done_q;
  assign quo  = quo_q;
endmodule

// File: rtl/slowdown_estimator.sv
module slowdown_estimator
  import slowdown_estimator_pkg::*;
#(
  parameter int N_APPS       = 4,
  parameter int INTERVAL_LEN = 512,
  localparam int ID_W = (N_APPS > 1) ? $clog2(N_APPS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_APPS-1:0] acc_hit,
  input  logic              hp_active,
  input  logic [ID_W-1:0]   hp_owner,
  input  logic [N_APPS-1:0] cont_miss,
  input  logic [N_APPS-1:0] miss_start,
  input  logic [N_APPS-1:0] miss_done,
  input  logic              grant_valid,
  input  logic [ID_W-1:0]   grant_id,
  input  logic [N_APPS-1:0] req_pending,
  output logic              sd_valid,
  input  logic              sd_ready,
  output logic [ID_W-1:0]   sd_app,
  output logic [OUT_W-1:0]  sd_value,
  output logic              sd_invalid
);
  localparam int CNT_W  = $clog2(INTERVAL_LEN + 1);
  localparam int PROD_W = 2 * CNT_W;
  localparam int DIV_W  = PROD_W + FRAC_W;
  localparam int DIFF_W = PROD_W + 2;

  logic tick;

  sde_interval_timer #(.INTERVAL_LEN(INTERVAL_LEN)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  logic [CNT_W-1:0] n_sh [N_APPS], n_hpa [N_APPS], n_hpc [N_APPS], n_cm [N_APPS];
  logic [CNT_W-1:0] n_svc [N_APPS], n_scn [N_APPS], n_q [N_APPS];

  sde_event_counters #(.N_APPS(N_APPS), .ID_W(ID_W), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .acc_hit(acc_hit), .hp_active(hp_active), .hp_owner(hp_owner),
    .cont_miss(cont_miss), .miss_start(miss_start), .miss_done(miss_done),
    .grant_valid(grant_valid), .grant_id(grant_id), .req_pending(req_pending),
    .sh_nxt(n_sh), .hpa_nxt(n_hpa), .hpc_nxt(n_hpc), .cm_nxt(n_cm),
    .svc_nxt(n_svc), .scn_nxt(n_scn), .q_nxt(n_q)
  );

  eng_state_e st_q;

  // Interval capture, taken only when the sequencer is free.
  logic [CNT_W-1:0] s_sh [N_APPS], s_hpa [N_APPS], s_hpc [N_APPS], s_cm [N_APPS];
  logic [CNT_W-1:0] s_svc [N_APPS], s_scn [N_APPS], s_q [N_APPS];
  logic capture;

  assign capture = tick && (st_q == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < N_APPS; a++) begin
        s_sh[a] <= '0; s_hpa[a] <= '0; s_hpc[a] <= '0; s_cm[a] <= '0;
        s_svc[a] <= '0; s_scn[a] <= '0; s_q[a] <= '0;
      end
    end else if (capture) begin
      for (int a = 0; a < N_APPS; a++) begin
        s_sh[a] <= n_sh[a]; s_hpa[a] <= n_hpa[a]; s_hpc[a] <= n_hpc[a];
        s_cm[a] <= n_cm[a]; s_svc[a] <= n_svc[a]; s_scn[a] <= n_scn[a];
        s_q[a] <= n_q[a];
      end
    end
  end

  logic [ID_W-1:0]  app_q;
  logic [CNT_W-1:0] avg_q, alone_q;
  logic             inv_q;
  logic [OUT_W-1:0] res_q;

  logic [CNT_W-1:0]         cur_sh, cur_hpa, cur_hpc, cur_cm, cur_svc, cur_scn, cur_q, sh_eff;
  logic [PROD_W-1:0]        cont_cyc;
  logic signed [DIFF_W-1:0] corr;
  logic                     corr_bad;
  logic [DIV_W-1:0]         main_num, main_den, div_num, div_den, div_quo;
  logic                     div_start, div_done;

  always_comb begin
    cur_sh   = s_sh[app_q];
    cur_hpa  = s_hpa[app_q];
    cur_hpc  = s_hpc[app_q];
    cur_cm   = s_cm[app_q];
    cur_svc  = s_svc[app_q];
    cur_scn  = s_scn[app_q];
    cur_q    = s_q[app_q];
    sh_eff   = (cur_sh == '0) ? CNT_W'(1) : cur_sh;
    cont_cyc = PROD_W'(cur_cm) * PROD_W'(avg_q);
    corr     = $signed(DIFF_W'(cur_hpc)) - $signed(DIFF_W'(cont_cyc)) - $signed(DIFF_W'(cur_q));
    corr_bad = (corr <= 0);
    main_num = {PROD_W'(cur_hpa) * PROD_W'(INTERVAL_LEN), {FRAC_W{1'b0}}};
    main_den = DIV_W'(PROD_W'(alone_q) * PROD_W'(sh_eff));
    div_start = (st_q == ST_AVG_GO) || (st_q == ST_MAIN_GO);
    div_num   = (st_q == ST_AVG_GO) ? DIV_W'(cur_svc) : main_num;
    div_den   = (st_q == ST_AVG_GO) ? DIV_W'(cur_scn) : main_den;
  end

  sde_seq_divider #(.W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start),
    .num(div_num), .den(div_den), .done(div_done), .quo(div_quo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      app_q   <= '0;
      avg_q   <= '0;
      alone_q <= '0;
      inv_q   <= 1'b0;
      res_q   <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (capture) begin
          app_q <= '0;
          st_q  <= ST_AVG_GO;
        end
        ST_AVG_GO: st_q <= ST_AVG_WAIT;
        ST_AVG_WAIT: if (div_done) begin
          avg_q <= (cur_scn == '0) ? '0 : div_quo[CNT_W-1:0];
          st_q  <= ST_PREP;
        end
        ST_PREP: begin
          inv_q   <= corr_bad;
          alone_q <= corr_bad ? CNT_W'(1) : corr[CNT_W-1:0];
          st_q    <= ST_MAIN_GO;
        end
        ST_MAIN_GO: st_q <= ST_MAIN_WAIT;
        ST_MAIN_WAIT: if (div_done) begin
          res_q <= (|div_quo[DIV_W-1:OUT_W]) ? {OUT_W{1'b1}} : div_quo[OUT_W-1:0];
          st_q  <= ST_OUT;
        end
        ST_OUT: if (sd_ready) begin
          if (app_q == ID_W'(N_APPS - 1)) begin
            st_q <= ST_IDLE;
          end else begin
            app_q <= app_q + 1'b1;
            st_q  <= ST_AVG_GO;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign sd_valid   = (st_q == ST_OUT);
  assign sd_app     = app_q;
  assign sd_value   = res_q;
  assign sd_invalid = inv_q;
endmodule

// File: rtl/slowdown_estimator_checker.sv
module slowdown_estimator_checker #(
  parameter int N_APPS = 4,
  parameter int ID_W   = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sd_valid,
  input logic            sd_ready,
  input logic [ID_W-1:0] sd_app,
  input logic [15:0]     sd_value,
  input logic            sd_invalid
);
  logic [ID_W-1:0] exp_app_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) exp_app_q <= '0;
    else if (sd_valid && sd_ready)
      exp_app_q <= (exp_app_q == ID_W'(N_APPS - 1)) ? '0 : exp_app_q + 1'b1;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!sd_valid && sd_value == 16'd0);
    end
  end

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sd_valid && !sd_ready |=> sd_valid && $stable(sd_app) && $stable(sd_value) && $stable(sd_invalid));

  assert_app_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sd_valid |-> sd_app == exp_app_q);

  assert_round_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sd_valid && sd_ready && sd_app == ID_W'(N_APPS - 1) |=> !sd_valid);
endmodule

bind slowdown_estimator slowdown_estimator_checker #(.N_APPS(N_APPS), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sd_valid(sd_valid), .sd_ready(sd_ready),
  .sd_app(sd_app), .sd_value(sd_value), .sd_invalid(sd_invalid)
);

// File: tb/slowdown_estimator_bench.sv
module slowdown_estimator_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int IL = 512;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] acc_hit = '0, cont_miss = '0, miss_start = '0, miss_done = '0, req_pending = '0;
  logic hp_active = 1'b0, grant_valid = 1'b0, sd_ready = 1'b1;
  logic [1:0] hp_owner = '0, grant_id = '0;
  logic sd_valid, sd_invalid;
  logic [1:0] sd_app;
  logic [15:0] sd_value;

  always #(CLK_PERIOD/2) clk = ~clk;

  slowdown_estimator #(.N_APPS(N), .INTERVAL_LEN(IL)) u_slowdown_estimator (
    .clk(clk), .rst_n(rst_n), .acc_hit(acc_hit), .hp_active(hp_active),
    .hp_owner(hp_owner), .cont_miss(cont_miss), .miss_start(miss_start),
    .miss_done(miss_done), .grant_valid(grant_valid), .grant_id(grant_id),
    .req_pending(req_pending), .sd_valid(sd_valid), .sd_ready(sd_ready),
    .sd_app(sd_app), .sd_value(sd_value), .sd_invalid(sd_invalid)
  );

  typedef struct { int app; longint val; bit inv; string tag; } exp_t;
  exp_t sb[$];
  int checks = 0, fails = 0;
  int rdy_mode = 0;
  bit [31:0] lfsr = 32'h1234_5678;
  bit [N-1:0] busy_m = '0;
  bit lg_v = 0;
  int lg_id = 0;

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(int p, int a, bit skip_run);
    if (skip_run) return "R10";
    case (p)
      0: return "R7";
      1: return (a == 0) ? "R2" : "R3";
      2: return (a == 0) ? "R4" : (a == 1) ? "R5" : (a == 2) ? "R6" : "R8";
      3: return (a == 1) ? "R7" : (a == 2) ? "R8" : "R11";
      default: return "R11";
    endcase
  endfunction

  // Drives one full interval; the model follows the requirements cycle by cycle.
  task automatic run_interval(int p, bit push, bit skip_run);
    longint sh[N], hpa[N], hpc[N], cm[N], svc[N], scn[N], qc[N];
    for (int a = 0; a < N; a++) begin
      sh[a] = 0; hpa[a] = 0; hpc[a] = 0; cm[a] = 0; svc[a] = 0; scn[a] = 0; qc[a] = 0;
    end
    for (int c = 0; c < IL; c++) begin
      bit hv; int ow; bit [N-1:0] ac, cmv, ms, md, pd; bit gv; int gi;
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      hv = 0; ow = 0; ac = '0; cmv = '0; ms = '0; md = '0; pd = '0; gv = 0; gi = 0;
      if (p == 1 || p == 2) begin
        hv = 1; ow = c / (IL / N); ac = lfsr[3:0];
      end
      if (p == 2) begin
        cmv = (c % 8 == 0) ? lfsr[7:4] : '0;
        for (int a = 0; a < N; a++) begin
          ms[a] = (c % 32 == 1);
          md[a] = (c % 32 == 5 + 2 * a);
        end
        gv = lfsr[8]; gi = int'(lfsr[10:9]); pd = lfsr[14:11];
      end
      if (p == 3) begin
        ac[0] = lfsr[5];
        if (c < 200) begin
          hv = 1; ow = 1; ac[1] = lfsr[0]; cmv[1] = 1'b1;
          ms[1] = (c % 16 == 0); md[1] = (c % 16 == 10);
        end else if (c < 202) begin
          hv = 1; ow = 2; ac[2] = 1'b1;
        end
      end
      acc_hit = ac; hp_active = hv; hp_owner = 2'(ow); cont_miss = cmv;
      miss_start = ms; miss_done = md; grant_valid = gv; grant_id = 2'(gi); req_pending = pd;
      for (int a = 0; a < N; a++) begin
        bit own;
        own = hv && (ow == a);
        sh[a] += ac[a];
        if (own) begin
          hpa[a] += ac[a]; hpc[a]++; cm[a] += cmv[a];
          if (busy_m[a]) svc[a]++;
          if (busy_m[a] && md[a]) scn[a]++;
          if (pd[a] && lg_v && lg_id != a) qc[a]++;
        end
      end
      for (int a = 0; a < N; a++) busy_m[a] = (busy_m[a] | ms[a]) & ~md[a];
      if (gv) begin lg_v = 1; lg_id = gi; end
      @(negedge clk);
    end
    if (push) begin
      for (int a = 0; a < N; a++) begin
        longint avg, d, alone, shf, v;
        exp_t e;
        avg = (scn[a] == 0) ? 0 : svc[a] / scn[a];
        d = hpc[a] - cm[a] * avg - qc[a];
        alone = (d <= 0) ? 1 : d;
        shf = (sh[a] == 0) ? 1 : sh[a];
        v = (hpa[a] * IL * 256) / (alone * shf);
        if (v > 65535) v = 65535;
        e.app = a; e.val = v; e.inv = (d <= 0); e.tag = tag_of(p, a, skip_run);
        sb.push_back(e);
      end
    end
  endtask

  // Monitor: chooses ready for the coming edge, then scores the transfer it makes.
  bit stalled = 0;
  logic [1:0] st_app; logic [15:0] st_val; logic st_inv;
  always @(negedge clk) begin
    if (rst_n) begin
      if (stalled) begin
        chk(sd_valid && sd_app == st_app && sd_value == st_val && sd_invalid == st_inv,
            "R9", "held result changed", longint'(sd_value), longint'(st_val));
      end
      if (rdy_mode == 0)      sd_ready = 1'b1;
      else if (rdy_mode == 1) sd_ready = lfsr[20] ^ lfsr[3];
      else                    sd_ready = 1'b0;
      stalled = sd_valid && !sd_ready;
      st_app = sd_app; st_val = sd_value; st_inv = sd_invalid;
      if (sd_valid && sd_ready) begin
        if (sb.size() == 0) begin
          chk(0, "R10", "unexpected result app", longint'(sd_app), -1);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(sd_app == 2'(e.app), e.tag, "app", longint'(sd_app), e.app);
          chk(sd_value == 16'(e.val), e.tag, $sformatf("value app%0d", e.app), longint'(sd_value), e.val);
          chk(sd_invalid == e.inv, e.tag, $sformatf("invalid app%0d", e.app), longint'(sd_invalid), longint'(e.inv));
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!sd_valid && sd_value == 16'd0, "R1", "reset outputs", longint'(sd_valid), 0);
    rst_n = 1'b1;
    chk(!sd_valid, "R1", "valid right after reset", longint'(sd_valid), 0);
    run_interval(0, 1, 0);
    rdy_mode = 1;
    run_interval(1, 1, 0);
    run_interval(2, 1, 0);
    rdy_mode = 0;
    run_interval(3, 1, 0);
    run_interval(1, 1, 0);
    run_interval(2, 1, 1);
    rdy_mode = 2;
    run_interval(1, 0, 0);
    rdy_mode = 0;
    run_interval(3, 1, 1);
    acc_hit = '0; hp_active = 0; cont_miss = '0; miss_start = '0; miss_done = '0;
    grant_valid = 0; req_pending = '0;
    for (int k = 0; k < 800 && sb.size() != 0; k++) @(negedge clk);
    chk(sb.size() == 0, "R10", "results outstanding", sb.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule